// File: doc/BRIEF.md
# Three-wire serial EEPROM slave front end

This block is the device side of a three-wire serial EEPROM port. It sees an active-low chip select, a serial clock and a serial data input, and it drives a serial data output with an output-enable and a ready/busy pin. All port inputs are brought into the block's own clock domain through synchronizers. Edges of the serial clock and chip select are then detected there, so the serial clock must be several times slower than the block clock. Behind the port sits a small register file that stands in for the memory array, and a programmable cycle counter that stands in for the self-timed write.

A transaction starts when chip select falls. If the serial clock is high at that moment, the block takes a command. The command is a 2-bit opcode and then an address, both most significant bit first, and a write also carries a data word. If the serial clock is low at that moment, the block enters status output mode. In that mode the data output shows whether the device is ready. Raising chip select before a command is complete discards it. Once a write has been launched, it finishes on its own while chip select and the serial clock do whatever they like.

Top module: `tw_eeprom_if`

## Requirements
- R1: After reset, rdy is 1 and dout_oe is 0. Writes are disabled, and every memory word reads as 0.
- R2: Chip select falling while sclk is high enters command mode. On each sclk rising edge one din bit is taken, most significant bit first: a 2-bit opcode, then AW address bits. The opcodes are 2'b10 read, 2'b01 write, 2'b11 write-enable and 2'b00 write-disable.
- R3: After a read command, each sclk falling edge drives the next bit of the addressed word onto dout, most significant bit first, with dout_oe high. After DW bits, the next falling edge drops dout_oe.
- R4: dout_oe is 0 whenever the block is not presenting read data or status, including within a few block clocks after chip select rises. dout_oe low means the data output is high impedance.
- R5: A write command carries DW data bits after the address. If writes are enabled, it stores the word and holds rdy at 0 for exactly WR_CYCLES block clock cycles, then returns rdy to 1.
- R6: A write issued without a preceding write-enable, or after a write-disable, leaves memory unchanged and rdy stays 1.
- R7: Chip select rising before the last bit of a command aborts it with no effect. A partial write stores nothing and leaves rdy at 1. A partial write-enable does not enable writes.
- R8: Chip select falling while sclk is low enters status mode. There dout_oe is 1 and dout is 0 while a write is in progress and 1 when ready.
- R9: A command started while rdy is 0 is ignored. A read gives no output, and a write stores nothing.
- R10: A launched write completes on time and stores its word even when chip select is raised and sclk and din toggle during the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |
| rdy | output | 1 | 1 when ready, 0 during a self-timed write |

## Verification
Several rules are checked on every cycle by assertions. The output enable never stays on once chip select has been high for more than a cycle, and it is only on in the read-out or status phases. A write is never launched while busy, and busy only rises after a launch. A status output follows busy falling. Only the bench scenarios can show the rest. These are the bit ordering of opcode, address and data, the exact length of the busy window, and the effect of enable and disable on later reads. They also cover the absence of effect from aborted or busy-time commands, and the completion of a write while the serial pins keep toggling.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    OP_WRDI  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_WREN  = 2'b11
  } tw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_STATUS,
    ST_HOLD
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[gi]}};
      else        chain <= {chain[STAGES-2:0], d[gi]};
    end
    assign q[gi] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      cnt_n  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;

  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          di_s,
  input  logic          busy,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic          wr_start,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          dout,
  output logic          dout_oe
);
  localparam int MAXB = (AW + 2 > DW) ? AW + 2 : DW;
  localparam int CNTW = $clog2(MAXB + 1);
  localparam logic [CNTW-1:0] ADDR_LAST = CNTW'(AW + 1);
  localparam logic [CNTW-1:0] DATA_LAST = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] DATA_LEN  = CNTW'(DW);

  tw_state_e     state_q, state_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [AW+1:0] sh_q, sh_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] buf_q, buf_n;
  logic          wen_q, wen_n;
  logic          dout_q, dout_n;
  logic          oe_q, oe_n;
  logic          cs_q, sck_q;
  logic          start;

  logic          cs_fall, sck_rise, sck_fall;
  logic [AW+1:0] word;
  tw_op_e        op;

  assign cs_fall  = cs_q & ~cs_s;
  assign sck_rise = ~sck_q & sck_s;
  assign sck_fall = sck_q & ~sck_s;
  assign word     = {sh_q[AW:0], di_s};
  assign op       = tw_op_e'(word[AW+1:AW]);
  assign raddr    = word[AW-1:0];

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    buf_n   = buf_q;
    wen_n   = wen_q;
    dout_n  = dout_q;
    oe_n    = oe_q;
    start   = 1'b0;
    if (cs_s) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cs_fall) begin
            if (!sck_s) begin
              state_n = ST_STATUS;
              oe_n    = 1'b1;
              dout_n  = ~busy;
            end else if (busy) begin
              state_n = ST_HOLD;
            end else begin
              state_n = ST_CMD;
              cnt_n   = '0;
            end
          end
        end
        ST_CMD: begin
          if (sck_rise) begin
            sh_n  = word;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == ADDR_LAST) begin
              cnt_n = '0;
              unique case (op)
                OP_READ: begin
                  buf_n   = rdata;
                  state_n = ST_RDATA;
                end
                OP_WRITE: begin
                  addr_n  = word[AW-1:0];
                  state_n = ST_WDATA;
                end
                OP_WREN: begin
                  wen_n   = 1'b1;
                  state_n = ST_HOLD;
                end
                OP_WRDI: begin
                  wen_n   = 1'b0;
                  state_n = ST_HOLD;
                end
              endcase
            end
          end
        end
        ST_WDATA: begin
          if (sck_rise) begin
            buf_n = {buf_q[DW-2:0], di_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == DATA_LAST) begin
              state_n = ST_HOLD;
              start   = wen_q;
            end
          end
        end
        ST_RDATA: begin
          if (sck_fall) begin
            if (cnt_q < DATA_LEN) begin
              oe_n   = 1'b1;
              dout_n = buf_q[DW-1];
              buf_n  = {buf_q[DW-2:0], 1'b0};
              cnt_n  = cnt_q + 1'b1;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_HOLD;
            end
          end
        end
        ST_STATUS: begin
          oe_n   = 1'b1;
          dout_n = ~busy;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      buf_q   <= '0;
      wen_q   <= 1'b0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      addr_q  <= addr_n;
      buf_q   <= buf_n;
      wen_q   <= wen_n;
      dout_q  <= dout_n;
      oe_q    <= oe_n;
      cs_q    <= cs_s;
      sck_q   <= sck_s;
    end
  end

  assign wr_start = start;
  assign waddr    = addr_q;
  assign wdata    = {buf_q[DW-2:0], di_s};
  assign dout     = dout_q;
  assign dout_oe  = oe_q;

  a_r4_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !oe_q);

  a_r3_oe_only_in_output_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !cs_s) |-> (state_q == ST_RDATA || state_q == ST_STATUS));

  a_r8_status_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && state_q == ST_STATUS && !cs_s) |=> dout_q);
endmodule

// File: rtl/tw_eeprom_if.sv
module tw_eeprom_if #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int WR_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic dout_oe,
  output logic rdy
);
  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  logic [2:0]    pins_s;
  logic          busy, wr_start;
  logic [AW-1:0] raddr, waddr;
  logic [DW-1:0] rdata, wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d({din, sclk, cs_n}), .q(pins_s)
  );

  tw_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .cs_s(pins_s[0]), .sck_s(pins_s[1]), .di_s(pins_s[2]),
    .busy(busy), .rdata(rdata), .raddr(raddr),
    .wr_start(wr_start), .waddr(waddr), .wdata(wdata),
    .dout(dout), .dout_oe(dout_oe)
  );

  tw_regfile #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_core_n), .we(wr_start),
    .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  tw_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .start(wr_start), .busy(busy)
  );

  assign rdy = ~busy;

  a_r9_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_start |-> !busy);

  a_r5_launch_makes_busy: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_start |=> !rdy);
endmodule

// File: tb/tw_eeprom_if_tb.sv
module tw_eeprom_if_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WR = 400;
  localparam int H  = 10;

  logic clk, rst_n, cs_n, sclk, din;
  logic dout, dout_oe, rdy;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] exp_q[$];
  logic rd_active = 1'b0;
  logic oe_seen = 1'b0;
  int low_cnt = 0;
  int last_len = 0;
  logic [DW-1:0] got = '0;
  int nbits = 0;

  tw_eeprom_if #(.AW(AW), .DW(DW), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (dout_oe) oe_seen <= 1'b1;
    if (!rdy) low_cnt <= low_cnt + 1;
    else if (low_cnt != 0) begin
      last_len <= low_cnt;
      low_cnt  <= 0;
    end
  end

  // scoreboard monitor: collects read-out bits and compares against queue
  always @(posedge sclk) begin
    if (rd_active && dout_oe) begin
      got = {got[DW-2:0], dout};
      nbits++;
      if (nbits == DW) begin
        nbits = 0;
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected read output", int'(got), -1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(got === e, "R3 read data", int'(got), int'(e));
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_cmd();
    sclk = 1'b1;
    wait_clk(H);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic deselect();
    wait_clk(H);
    cs_n = 1'b1;
    sclk = 1'b1;
    wait_clk(H);
  endtask

  task automatic shift(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      din  = v[i];
      wait_clk(H);
      sclk = 1'b1;
      wait_clk(H);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input logic valid);
    sel_cmd();
    shift({2'b10, a}, 2 + AW);
    if (valid) exp_q.push_back(e);
    nbits = 0;
    oe_seen = 1'b0;
    rd_active = 1'b1;
    for (int i = 0; i < DW + 1; i++) begin
      sclk = 1'b0;
      wait_clk(H);
      sclk = 1'b1;
      wait_clk(H);
    end
    rd_active = 1'b0;
    if (valid) check(dout_oe == 1'b0, "R3 oe drops after last bit", dout_oe, 0);
    deselect();
    check(dout_oe == 1'b0, "R4 oe low when deselected", dout_oe, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_cmd();
    shift({2'b01, a, d}, 2 + AW + DW);
    deselect();
  endtask

  task automatic do_op(input logic [1:0] op);
    sel_cmd();
    shift({op, {AW{1'b0}}}, 2 + AW);
    deselect();
  endtask

  task automatic wait_ready();
    wait_clk(5);
    while (!rdy) @(negedge clk);
    wait_clk(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check(rdy == 1'b1, "R1 rdy after reset", rdy, 1);
    check(dout_oe == 1'b0, "R1 oe after reset", dout_oe, 0);
    do_read(4'd3, 8'h00, 1'b1);      // R1 memory zero, R2 read opcode
    // R6 write without enable
    last_len = 0;
    do_write(4'd5, 8'hA5);
    wait_clk(WR + 20);
    check(last_len == 0 && rdy, "R6 no busy without enable", last_len, 0);
    do_read(4'd5, 8'h00, 1'b1);
    // R5 enabled write
    do_op(2'b11);
    do_write(4'd5, 8'hA5);
    check(rdy == 1'b0, "R5 busy after write", rdy, 0);
    wait_ready();
    check(last_len == WR, "R5 busy length", last_len, WR);
    do_read(4'd5, 8'hA5, 1'b1);
    // R7 aborted write
    last_len = 0;
    sel_cmd();
    shift({2'b01, 4'd6, 4'hF}, 2 + AW + 4);
    deselect();
    wait_clk(20);
    check(rdy == 1'b1 && last_len == 0, "R7 partial write no busy", rdy, 1);
    do_read(4'd6, 8'h00, 1'b1);
    // R8 status mode while busy, then ready
    do_write(4'd7, 8'h3C);
    sclk = 1'b0;
    wait_clk(5);
    cs_n = 1'b0;
    wait_clk(8);
    check(dout_oe == 1'b1, "R8 status oe", dout_oe, 1);
    check(dout == 1'b0, "R8 status busy value", dout, 0);
    while (!rdy) @(negedge clk);
    wait_clk(8);
    check(dout == 1'b1, "R8 status ready value", dout, 1);
    cs_n = 1'b1;
    wait_clk(8);
    check(dout_oe == 1'b0, "R4 oe low after status", dout_oe, 0);
    sclk = 1'b1;
    wait_clk(H);
    do_read(4'd7, 8'h3C, 1'b1);
    // R9 read during busy ignored
    do_write(4'd8, 8'h11);
    do_read(4'd5, 8'h00, 1'b0);
    check(oe_seen == 1'b0, "R9 read ignored while busy", oe_seen, 0);
    wait_ready();
    // R9 write during busy ignored
    do_write(4'd9, 8'h22);
    do_write(4'd9, 8'h77);
    wait_ready();
    do_read(4'd9, 8'h22, 1'b1);
    // R10 write finishes with pins toggling
    sel_cmd();
    shift({2'b01, 4'hA, 8'h5A}, 2 + AW + DW);
    wait_clk(3);
    cs_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sclk = ~sclk;
      din  = ~din;
      wait_clk(5);
    end
    sclk = 1'b1;
    wait_ready();
    check(last_len == WR, "R10 busy length with toggling", last_len, WR);
    do_read(4'hA, 8'h5A, 1'b1);
    // R6 after write-disable
    do_op(2'b00);
    last_len = 0;
    do_write(4'hB, 8'hFF);
    wait_clk(WR + 20);
    check(last_len == 0, "R6 write-disable blocks", last_len, 0);
    do_read(4'hB, 8'h00, 1'b1);
    // R7 partial write-enable
    sel_cmd();
    shift({2'b11, 2'b00}, 4);
    deselect();
    do_write(4'hB, 8'hEE);
    wait_clk(WR + 20);
    do_read(4'hB, 8'h00, 1'b1);
    check(last_len == 0, "R7 partial enable no effect", last_len, 0);
    check(exp_q.size() == 0, "R3 all expected reads seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule